// File: doc/BRIEF.md
# Dual-Stack Execution Datapath

This block is the execute stage of a small stack processor. It keeps a data stack whose top element sits in a register (T) and whose second element (N) is the head of a circular register file. A second circular register file forms a return stack whose head is R. Instruction fetch, sequencing and literals belong to neighbouring logic. Each cycle that neighbour may present one instruction word. The datapath then computes a new T and may copy T into N or R, write N to data memory or to the I/O port at address T, and step each stack pointer by -1, 0 or +1.

An instruction word is not an opcode from a fixed list. It is a bundle of independent fields: a T-source select, copy flags, store flags, two pointer steps and a return flag. The familiar stack words (add, swap, over, push-to-return, exit and the rest) are particular values of these fields. A read from I/O takes two cycles. While the data comes back, the block raises `hold` and ignores the instruction input.

Top module: `stack_datapath`

## Requirements
- R1: While rst_n is low, t_out, n_out, r_out and depth_out read zero, and hold, ret_pulse, mem_we, io_we and io_rd are low.
- R2: T-source codes 2, 3, 4, 5 and 6 load T with T+N, N-T, T^N, T&N and T|N respectively (mod 2^DW). The standard encodings of these operations use a data step of -1, after which N is the element that was below the old N.
- R3: T-source code 7 loads ~T. Code 11 loads T shifted right one place with the sign bit kept. Code 12 loads T shifted left one place with a zero shifted in. A data step of 0 leaves depth_out unchanged.
- R4: T-source codes 8, 9 and 10 load T with N==T, signed N<T and unsigned N<T. A true result is all ones and a false result is all zeros.
- R5: T-source code 0 keeps T and code 1 loads N. Together with the T-to-N copy and the data step, these give swap (1, copy, 0), dup (0, copy, +1), over (1, copy, +1), drop (1, no copy, -1) and nip (0, no copy, -1).
- R6: Code 13 loads T from R. The T-to-R copy with a return step of +1 pushes the old T so that R equals it next cycle. A return step of -1 pops R.
- R7: When the memory-store flag is set in an accepted instruction, mem_we is high in that same cycle, with mem_addr equal to T and mem_wdata equal to N.
- R8: When the I/O-store flag is set in an accepted instruction, io_we is high in that same cycle, with io_addr equal to T and io_wdata equal to N.
- R9: Code 14 raises io_rd in the accepting cycle with io_addr equal to T, and hold is high in the next cycle. At the end of that hold cycle, T takes io_rdata. During hold, op_valid is ignored and no strobe is raised.
- R10: Code 15 loads T with the current depth_out value, zero-extended.
- R11: The return flag raises ret_pulse in the accepting cycle. The exit encoding (code 0, return step -1) leaves T unchanged and pops R.
- R12: Both stack pointers wrap modulo DEPTH with no trap. DEPTH+4 pushes from reset leave depth_out at 4.
- R13: Instruction word layout: [3:0] T-source, [4] copy T to N, [5] copy T to R, [6] store N to memory, [7] store N to I/O, [9:8] data step, [11:10] return step, [12] return flag. A step field of 01 means +1, 11 means -1, and 00 or 10 means 0. A copy writes into the slot the pointer reaches after its step.
- R14: With op_valid low and hold low, T, N, R and depth_out do not change and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_word | input | 13 | Field-encoded instruction (R13) |
| io_rdata | input | DW | I/O read data, sampled in the hold cycle |
| t_out | output | DW | Top of data stack |
| n_out | output | DW | Second data stack element |
| r_out | output | DW | Top of return stack |
| depth_out | output | log2(DEPTH) | Data stack pointer |
| hold | output | 1 | I/O fetch completing; instruction input ignored |
| ret_pulse | output | 1 | Return flag of the accepted instruction |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | DW | Data memory address (T) |
| mem_wdata | output | DW | Data memory write data (N) |
| io_we | output | 1 | I/O write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_addr | output | DW | I/O address (T) |
| io_wdata | output | DW | I/O write data (N) |

## Verification
A wrong pointer or a corrupted stack slot stays hidden until some later instruction exposes it. A slot written one position off shows on n_out only after a drop or a nip reaches it, and a bad return-stack pointer shows only after a pop or an exit. For this reason the reference model compares T, N, R, depth and hold after every clock edge, and compares the memory and I/O strobes, addresses and data in the accepting cycle. Long random instruction streams that mix pushes, pops and pointer wraps bring buried errors to the ports within a few instructions. Directed sequences cover the signed/unsigned compare boundary and the two-cycle I/O fetch.

// File: rtl/stkdp_pkg.sv
`timescale 1ns/1ps
package stkdp_pkg;

  localparam int OPW = 13;

  typedef enum logic [3:0] {
    TS_T     = 4'd0,
    TS_N     = 4'd1,
    TS_ADD   = 4'd2,
    TS_SUB   = 4'd3,
    TS_XOR   = 4'd4,
    TS_AND   = 4'd5,
    TS_OR    = 4'd6,
    TS_INV   = 4'd7,
    TS_EQ    = 4'd8,
    TS_LTS   = 4'd9,
    TS_LTU   = 4'd10,
    TS_HALF  = 4'd11,
    TS_DBL   = 4'd12,
    TS_R     = 4'd13,
    TS_IORD  = 4'd14,
    TS_DEPTH = 4'd15
  } tsel_e;

  // Field layout of the instruction word, MSB first (R13)
  typedef struct packed {
    logic       ret;
    logic [1:0] rstep;
    logic [1:0] dstep;
    logic       n_io;
    logic       n_mem;
    logic       t_r;
    logic       t_n;
    tsel_e      tsel;
  } op_t;

endpackage

// File: rtl/stkdp_alu.sv
`timescale 1ns/1ps
module stkdp_alu #(
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  stkdp_pkg::tsel_e tsel,
  input  logic [DW-1:0]    t,
  input  logic [DW-1:0]    n,
  input  logic [DW-1:0]    r,
  input  logic [PW-1:0]    depth,
  output logic [DW-1:0]    res
);
  import stkdp_pkg::*;

  localparam logic [DW-1:0] ALL1 = '1;
  localparam logic [DW-1:0] ALL0 = '0;

  always_comb begin
    unique case (tsel)
      TS_T:     res = t;
      TS_N:     res = n;
      TS_ADD:   res = t + n;
      TS_SUB:   res = n - t;
      TS_XOR:   res = t ^ n;
      TS_AND:   res = t & n;
      TS_OR:    res = t | n;
      TS_INV:   res = ~t;
      TS_EQ:    res = (n == t) ? ALL1 : ALL0;
      TS_LTS:   res = ($signed(n) < $signed(t)) ? ALL1 : ALL0;
      TS_LTU:   res = (n < t) ? ALL1 : ALL0;
      TS_HALF:  res = {t[DW-1], t[DW-1:1]};
      TS_DBL:   res = {t[DW-2:0], 1'b0};
      TS_R:     res = r;
      TS_DEPTH: res = DW'(depth);
      default:  res = t;   // I/O fetch: T loaded later from the port
    endcase
  end
endmodule

// File: rtl/stkdp_lifo.sv
`timescale 1ns/1ps
// Circular register-file stack; DEPTH must be a power of two so the
// pointer wraps naturally.
module stkdp_lifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    step,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] slot [DEPTH];

  always_comb begin
    unique case (step)
      2'b01:   ptr_d = ptr_q + PW'(1);
      2'b11:   ptr_d = ptr_q - PW'(1);
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (en) ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = en && wr && (ptr_d == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot[i] <= '0;
      else if (slot_en) slot[i] <= wdata;
    end
  end

  assign top = slot[ptr_q];
  assign ptr = ptr_q;
endmodule

// File: rtl/stack_datapath.sv
`timescale 1ns/1ps
module stack_datapath #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [stkdp_pkg::OPW-1:0] op_word,
  input  logic [DW-1:0]           io_rdata,
  output logic [DW-1:0]           t_out,
  output logic [DW-1:0]           n_out,
  output logic [DW-1:0]           r_out,
  output logic [PW-1:0]           depth_out,
  output logic                    hold,
  output logic                    ret_pulse,
  output logic                    mem_we,
  output logic [DW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  output logic                    io_we,
  output logic                    io_rd,
  output logic [DW-1:0]           io_addr,
  output logic [DW-1:0]           io_wdata
);
  import stkdp_pkg::*;

  op_t           op;
  logic          accept;
  logic [DW-1:0] t_q, t_d, alu_res, n_top, r_top;
  logic          t_en;
  logic          pend_q, pend_d;
  logic [PW-1:0] dptr, rptr;

  assign op     = op_t'(op_word);
  assign accept = op_valid && !pend_q;

  stkdp_alu #(.DW(DW), .PW(PW)) u_alu (
    .tsel  (op.tsel),
    .t     (t_q),
    .n     (n_top),
    .r     (r_top),
    .depth (dptr),
    .res   (alu_res)
  );

  stkdp_lifo #(.DW(DW), .DEPTH(DEPTH)) u_dstk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (accept),
    .step  (op.dstep),
    .wr    (op.t_n),
    .wdata (t_q),
    .top   (n_top),
    .ptr   (dptr)
  );

  stkdp_lifo #(.DW(DW), .DEPTH(DEPTH)) u_rstk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (accept),
    .step  (op.rstep),
    .wr    (op.t_r),
    .wdata (t_q),
    .top   (r_top),
    .ptr   (rptr)
  );

  // Next-state for T and the I/O fetch pending flag
  always_comb begin
    pend_d = accept && (op.tsel == TS_IORD);
    t_en   = pend_q || (accept && (op.tsel != TS_IORD));
    t_d    = pend_q ? io_rdata : alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= '0;
    else if (t_en) t_q <= t_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign t_out     = t_q;
  assign n_out     = n_top;
  assign r_out     = r_top;
  assign depth_out = dptr;
  assign hold      = pend_q;
  assign ret_pulse = accept && op.ret;
  assign mem_we    = accept && op.n_mem;
  assign mem_addr  = t_q;
  assign mem_wdata = n_top;
  assign io_we     = accept && op.n_io;
  assign io_rd     = pend_d;
  assign io_addr   = t_q;
  assign io_wdata  = n_top;

  logic unused_rptr;
  assign unused_rptr = ^rptr;
endmodule

// File: rtl/stack_datapath_chk.sv
`timescale 1ns/1ps
module stack_datapath_chk #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [12:0]   op_word,
  input logic [DW-1:0] t_out,
  input logic [DW-1:0] n_out,
  input logic [DW-1:0] r_out,
  input logic [PW-1:0] depth_out,
  input logic          hold,
  input logic          ret_pulse,
  input logic          mem_we,
  input logic          io_we,
  input logic          io_rd
);
  logic acc;
  logic is_cmp;
  assign acc    = op_valid && !hold;
  assign is_cmp = (op_word[3:0] == 4'd8) || (op_word[3:0] == 4'd9) ||
                  (op_word[3:0] == 4'd10);

  assert_read_then_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> hold);

  assert_hold_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !(mem_we || io_we || io_rd || ret_pulse));

  assert_idle_keeps_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !hold) |=> ($stable(t_out) && $stable(n_out) &&
                              $stable(r_out) && $stable(depth_out)));

  assert_push_wraps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_word[9:8] == 2'b01) |=> depth_out == PW'($past(depth_out) + 1'b1));

  assert_pop_wraps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_word[9:8] == 2'b11) |=> depth_out == PW'($past(depth_out) - 1'b1));

  assert_cmp_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_cmp) |=> (t_out == '0 || t_out == '1));

  assert_exit_keeps_t_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_word[12] && op_word[3:0] == 4'd0) |=> $stable(t_out));
endmodule

bind stack_datapath stack_datapath_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_word   (op_word),
  .t_out     (t_out),
  .n_out     (n_out),
  .r_out     (r_out),
  .depth_out (depth_out),
  .hold      (hold),
  .ret_pulse (ret_pulse),
  .mem_we    (mem_we),
  .io_we     (io_we),
  .io_rd     (io_rd)
);

// File: tb/stack_datapath_tb.sv
`timescale 1ns/1ps
module stack_datapath_tb;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int PW = 4;
  localparam int NOPS = 24;

  logic          clk, rst_n, op_valid;
  logic [12:0]   op_word;
  logic [DW-1:0] io_rdata;
  logic [DW-1:0] t_out, n_out, r_out, mem_addr, mem_wdata, io_addr, io_wdata;
  logic [PW-1:0] depth_out;
  logic          hold, ret_pulse, mem_we, io_we, io_rd;

  stack_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .io_rdata(io_rdata), .t_out(t_out), .n_out(n_out), .r_out(r_out),
    .depth_out(depth_out), .hold(hold), .ret_pulse(ret_pulse),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .io_we(io_we), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference model state
  logic [DW-1:0] m_t;
  logic [DW-1:0] m_ds [DEPTH];
  logic [DW-1:0] m_rs [DEPTH];
  int            m_dp, m_rp;
  bit            m_hold;

  logic [12:0] ops [NOPS];
  string       tags [NOPS];

  localparam logic [1:0] P = 2'b01, M = 2'b11, Z = 2'b00;

  function automatic logic [12:0] mk(int ts, bit tn, bit tr, bit nm, bit ni,
                                     logic [1:0] d, logic [1:0] r, bit rt);
    return {rt, r, d, ni, nm, tr, tn, 4'(ts)};
  endfunction

  function automatic int stepv(logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b11) return DEPTH - 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_t = '0; m_dp = 0; m_rp = 0; m_hold = 0;
    for (int i = 0; i < DEPTH; i++) begin m_ds[i] = '0; m_rs[i] = '0; end
  endtask

  task automatic model_step(bit v, logic [12:0] w, logic [DW-1:0] iod);
    logic [DW-1:0] ot, on, orr, nt;
    int ts;
    if (m_hold) begin
      m_t = iod; m_hold = 0;
    end else if (v) begin
      ot = m_t; on = m_ds[m_dp]; orr = m_rs[m_rp]; ts = int'(w[3:0]);
      case (ts)
        0: nt = ot;            1: nt = on;
        2: nt = ot + on;       3: nt = on - ot;
        4: nt = ot ^ on;       5: nt = ot & on;
        6: nt = ot | on;       7: nt = ~ot;
        8: nt = (on == ot) ? 16'hFFFF : 16'h0000;
        9: nt = ($signed(on) < $signed(ot)) ? 16'hFFFF : 16'h0000;
        10: nt = (on < ot) ? 16'hFFFF : 16'h0000;
        11: nt = $unsigned($signed(ot) >>> 1);
        12: nt = ot << 1;
        13: nt = orr;
        15: nt = DW'(m_dp);
        default: nt = ot;
      endcase
      m_dp = (m_dp + stepv(w[9:8])) % DEPTH;
      if (w[4]) m_ds[m_dp] = ot;
      m_rp = (m_rp + stepv(w[11:10])) % DEPTH;
      if (w[5]) m_rs[m_rp] = ot;
      if (ts == 14) m_hold = 1; else m_t = nt;
    end
  endtask

  task automatic check_comb(bit v, logic [12:0] w, string tag);
    bit acc;
    acc = v && !m_hold;
    chk(tag, "mem_we", 16'(mem_we), 16'(acc && w[6]));
    chk(tag, "io_we", 16'(io_we), 16'(acc && w[7]));
    chk(tag, "io_rd", 16'(io_rd), 16'(acc && w[3:0] == 4'd14));
    chk(tag, "ret_pulse", 16'(ret_pulse), 16'(acc && w[12]));
    if (acc && w[6]) begin
      chk(tag, "mem_addr", mem_addr, m_t);
      chk(tag, "mem_wdata", mem_wdata, m_ds[m_dp]);
    end
    if (acc && (w[7] || w[3:0] == 4'd14)) chk(tag, "io_addr", io_addr, m_t);
    if (acc && w[7]) chk(tag, "io_wdata", io_wdata, m_ds[m_dp]);
  endtask

  task automatic check_state(string tag);
    chk(tag, "t_out", t_out, m_t);
    chk(tag, "n_out", n_out, m_ds[m_dp]);
    chk(tag, "r_out", r_out, m_rs[m_rp]);
    chk(tag, "depth_out", 16'(depth_out), 16'(m_dp));
    chk(tag, "hold", 16'(hold), 16'(m_hold));
  endtask

  // One clock: called at a falling edge, returns at the next falling edge
  task automatic cycle(bit v, logic [12:0] w, logic [DW-1:0] iod, string tag);
    op_valid = v; op_word = w; io_rdata = iod;
    #1;
    check_comb(v, w, tag);
    @(posedge clk);
    model_step(v, w, iod);
    @(negedge clk);
    check_state(tag);
  endtask

  // dup followed by a two-cycle I/O fetch: pushes val
  task automatic push(logic [DW-1:0] val);
    cycle(1, ops[0], 16'h0, "R5");
    cycle(1, ops[21], 16'hDEAD, "R9");
    cycle(1, ops[1], val, "R9");   // op ignored during hold
  endtask

  initial begin
    ops[0]  = mk(0, 1,0,0,0, P, Z, 0); tags[0]  = "R5";   // dup
    ops[1]  = mk(2, 0,0,0,0, M, Z, 0); tags[1]  = "R2";   // add
    ops[2]  = mk(3, 0,0,0,0, M, Z, 0); tags[2]  = "R2";   // sub
    ops[3]  = mk(4, 0,0,0,0, M, Z, 0); tags[3]  = "R2";
    ops[4]  = mk(5, 0,0,0,0, M, Z, 0); tags[4]  = "R2";
    ops[5]  = mk(6, 0,0,0,0, M, Z, 0); tags[5]  = "R2";
    ops[6]  = mk(7, 0,0,0,0, Z, Z, 0); tags[6]  = "R3";
    ops[7]  = mk(8, 0,0,0,0, M, Z, 0); tags[7]  = "R4";
    ops[8]  = mk(9, 0,0,0,0, M, Z, 0); tags[8]  = "R4";
    ops[9]  = mk(10,0,0,0,0, M, Z, 0); tags[9]  = "R4";
    ops[10] = mk(11,0,0,0,0, Z, Z, 0); tags[10] = "R3";
    ops[11] = mk(12,0,0,0,0, Z, Z, 0); tags[11] = "R3";
    ops[12] = mk(1, 1,0,0,0, Z, Z, 0); tags[12] = "R5";   // swap
    ops[13] = mk(1, 1,0,0,0, P, Z, 0); tags[13] = "R5";   // over
    ops[14] = mk(1, 0,0,0,0, M, Z, 0); tags[14] = "R5";   // drop
    ops[15] = mk(0, 0,0,0,0, M, Z, 0); tags[15] = "R5";   // nip
    ops[16] = mk(1, 0,1,0,0, M, P, 0); tags[16] = "R6";   // to return
    ops[17] = mk(13,1,0,0,0, P, M, 0); tags[17] = "R6";   // from return
    ops[18] = mk(13,1,0,0,0, P, Z, 0); tags[18] = "R6";   // copy return
    ops[19] = mk(1, 0,0,1,0, M, Z, 0); tags[19] = "R7";   // memory store
    ops[20] = mk(1, 0,0,0,1, M, Z, 0); tags[20] = "R8";   // I/O store
    ops[21] = mk(14,0,0,0,0, Z, Z, 0); tags[21] = "R9";   // I/O fetch
    ops[22] = mk(15,1,0,0,0, P, Z, 0); tags[22] = "R10";  // depth
    ops[23] = mk(0, 0,0,0,0, Z, M, 1); tags[23] = "R11";  // exit

    rst_n = 1'b0; op_valid = 1'b0; op_word = '0; io_rdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check_state("R1");
    check_comb(0, 13'h0, "R1");
    rst_n = 1'b1;

    // R12: wrap of the data pointer after DEPTH+4 pushes
    for (int i = 0; i < DEPTH + 4; i++) cycle(1, ops[22], 16'h0, "R12");
    chk("R12", "depth after wrap", 16'(depth_out), 16'd4);

    // R4: signed versus unsigned boundary
    push(16'h8000); push(16'h0001);
    cycle(1, ops[8], 16'h0, "R4");   // signed 0x8000 < 1 -> true
    chk("R4", "signed lt", t_out, 16'hFFFF);
    push(16'h8000); push(16'h0001);
    cycle(1, ops[9], 16'h0, "R4");   // unsigned -> false
    chk("R4", "unsigned lt", t_out, 16'h0000);

    // R2 / R3 arithmetic
    push(16'h7FFF); push(16'h0003);
    cycle(1, ops[1], 16'h0, "R2");
    chk("R2", "add", t_out, 16'h8002);
    cycle(1, ops[10], 16'h0, "R3");
    chk("R3", "halve keeps sign", t_out, 16'hC001);

    // R6 / R11 return stack round trip
    push(16'hA5A5);
    cycle(1, ops[16], 16'h0, "R6");
    chk("R6", "R after push", r_out, 16'hA5A5);
    cycle(1, ops[23], 16'h0, "R11");

    // R7 / R8 stores followed by drop
    push(16'h0042); push(16'h0010);
    cycle(1, ops[19], 16'h0, "R7");
    cycle(1, ops[14], 16'h0, "R7");
    push(16'h0055); push(16'h0020);
    cycle(1, ops[20], 16'h0, "R8");
    cycle(1, ops[14], 16'h0, "R8");

    // R14: idle cycles with garbage on the word
    for (int i = 0; i < 8; i++) cycle(0, 13'($urandom), 16'($urandom), "R14");

    // R13: random field-encoded instruction stream
    for (int i = 0; i < 5000; i++) begin
      int k;
      bit v;
      k = $urandom_range(0, NOPS - 1);
      v = ($urandom % 8) != 0;
      cycle(v, ops[k], 16'($urandom), v ? tags[k] : "R14");
      if (i % 500 == 0) cycle(1, 13'($urandom), 16'($urandom), "R13");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule